// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block sits between an interrupt priority arbiter and the processor bus. It counts the processor's interrupt-acknowledge pulses and, on each one, decides whether to drive the data bus and with which byte. It has two bus personalities. The long one uses three pulses: a subroutine-call opcode, then the low byte of the handler address, then its high byte. The short one uses two pulses: the first only freezes arbitration, and the second returns an 8-bit vector.

When controllers are chained, the block drives the slave identity on a 3-bit cascade bus when it is the master. When it is a slave, it drives its vector bytes only when the cascade bus carries its own identity. If the request has disappeared by the first pulse, it answers as the lowest level. It also turns a read that follows a poll command into an acknowledge, returning the pending level as a status byte. It emits one-cycle strobes that the in-service logic uses: freeze, set-in-service with a level, and automatic end-of-interrupt.

Both strobes are active-low, asynchronous to the clock, and pass through a synchronizer before their edges are detected. Register programming lives elsewhere; every setting arrives here as a static configuration input.

Top module: `ack_vector_seq`

## Requirements
- R1: In three-pulse mode (`cfg_two_pulse`=0), a master or a standalone controller drives 0xCD during the first acknowledge, the low address byte during the second and `cfg_page_hi` during the third.
- R2: The low address byte is `{cfg_page_lo, level, 2'b00}` when `cfg_ivl4`=1 and `{cfg_page_lo[2:1], level, 3'b000}` when `cfg_ivl4`=0.
- R3: In two-pulse mode, the first acknowledge leaves `data_oe` low, and the second drives `{cfg_vec_base, level}` whatever the value of `cfg_ivl4`.
- R4: `aeoi` pulses for one cycle after the trailing edge of the last acknowledge of a sequence (the third or the second, depending on mode) only when `cfg_auto_eoi`=1. It never pulses after an earlier pulse.
- R5: If `win_valid` is low at the first acknowledge, the bytes and the cascade identity are those of level 7, and `set_isr` does not pulse.
- R6: A cascaded master (`cfg_cascaded`=1, `cfg_master`=1) drives `cas_out`=level from the end of the first acknowledge to the end of the last when `cfg_id_map[level]`=1. In that case it does not drive the address or vector bytes. In every other case `cas_out` stays 0.
- R7: A cascaded slave never drives the first byte of a sequence. It drives the later bytes only while `cas_in` equals `cfg_id_map[2:0]`.
- R8: After a `poll_arm` pulse, the next read returns `{win_valid, 4'b0000, level}` (level 0 when nothing is pending) and pulses `set_isr` if a request is pending. A read without an armed poll leaves `data_oe` low.
- R9: `data_oe` is high only while a synchronized acknowledge or poll read is in progress. It is low out of reset and after every strobe ends.
- R10: A `cfg_init` pulse returns the pulse counter to the start of a sequence, so the next acknowledge is treated as a first one.
- R11: At the first acknowledge of a sequence and at a poll read, `freeze` pulses for exactly one cycle. `set_isr` pulses in the same cycle with `set_level` equal to `win_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_init | input | 1 | One-cycle pulse: initialization restarts the sequence |
| poll_arm | input | 1 | One-cycle pulse: a poll command was written |
| ack_n | input | 1 | Interrupt-acknowledge strobe, active low, asynchronous |
| rd_n | input | 1 | Selected read strobe, active low, asynchronous |
| win_valid | input | 1 | Arbiter has a winning request |
| win_level | input | 3 | Winning level from the arbiter |
| cfg_two_pulse | input | 1 | 1 = two-pulse vector mode, 0 = three-pulse call mode |
| cfg_ivl4 | input | 1 | 1 = handler spacing of 4, 0 = spacing of 8 |
| cfg_auto_eoi | input | 1 | Automatic end-of-interrupt enable |
| cfg_cascaded | input | 1 | More than one controller in the system |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_id_map | input | 8 | Master: one bit per level with a slave behind it; slave: bits 2:0 = own identity |
| cfg_page_lo | input | 3 | Handler address bits 7..5 |
| cfg_page_hi | input | 8 | Handler address bits 15..8 |
| cfg_vec_base | input | 5 | Upper five bits of the two-pulse vector |
| cas_in | input | 3 | Cascade bus as seen by a slave |
| data_out | output | 8 | Byte presented to the data bus |
| data_oe | output | 1 | Data bus drive enable |
| cas_out | output | 3 | Cascade bus driven by a master |
| freeze | output | 1 | One-cycle pulse: hold arbitration |
| set_isr | output | 1 | One-cycle pulse: set the in-service bit |
| set_level | output | 3 | Level to mark in service |
| aeoi | output | 1 | One-cycle pulse: non-specific end-of-interrupt |

## Verification
The assertions take for granted that the configuration inputs and `cas_in` do not change inside an acknowledge sequence. They also assume that an acknowledge and a poll read never overlap, and that each strobe stays low and high for several clocks so that the synchronizer sees every edge. The stimulus changes settings only between complete sequences. It holds each strobe level for six clocks, sets `cas_in` before the first pulse of a sequence, and issues poll reads only when no acknowledge is in progress.

// File: rtl/ackseq_pkg.sv
// Package: shared widths and constants for the acknowledge vector sequencer.
// Assumes an 8-bit data bus and eight request levels.
package ackseq_pkg;
    localparam int LVL_W     = 3;
    localparam int N_LVL     = 1 << LVL_W;
    localparam int DATA_W    = 8;
    localparam int PAGE_LO_W = DATA_W - LVL_W - 2;
    localparam int VBASE_W   = DATA_W - LVL_W;
    localparam int IDX_W     = 2;

    localparam logic [DATA_W-1:0] CALL_OPCODE  = 8'hCD;
    localparam logic [LVL_W-1:0]  LVL_FALLBACK = LVL_W'(N_LVL - 1);

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/strobe_edge.sv
// Module: strobe_edge
// Brings an asynchronous active-low strobe into the clock domain through a
// STAGES-deep synchronizer, then reports its level and both of its edges.
// Assumes the strobe holds each level for longer than STAGES+1 clocks.
module strobe_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic active,
    output logic start,
    output logic finish
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchronizer chain: stage 0 samples the pin, later stages retime it.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= strobe_n;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Edge memory: previous value of the synchronized strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign active = ~sync_q[STAGES-1];
    assign start  = prev_q & ~sync_q[STAGES-1];
    assign finish = ~prev_q & sync_q[STAGES-1];
endmodule

// File: rtl/cascade_sel.sv
// Module: cascade_sel
// Decides the cascade role for the level being acknowledged: the identity a
// master places on the cascade bus, whether the master leaves the vector
// bytes to a slave, and whether a slave is addressed by the cascade bus.
// Purely combinational; assumes cas_in is stable during a sequence.
module cascade_sel
    import ackseq_pkg::*;
(
    input  logic             cascaded,
    input  logic             master,
    input  logic [N_LVL-1:0] id_map,
    input  lvl_t             level,
    input  lvl_t             cas_in,
    output lvl_t             master_cas,
    output logic             master_defers,
    output logic             slave_role,
    output logic             slave_hit
);
    logic level_has_slave;

    // Role and selection decode.
    always_comb begin
        level_has_slave = id_map[level];
        master_defers   = cascaded & master & level_has_slave;
        master_cas      = master_defers ? level : '0;
        slave_role      = cascaded & ~master;
        slave_hit       = slave_role & (cas_in == id_map[LVL_W-1:0]);
    end
endmodule

// File: rtl/vector_fmt.sv
// Module: vector_fmt
// Builds the byte for a given pulse index of the acknowledge sequence, or
// the status byte of a poll read. Purely combinational.
module vector_fmt
    import ackseq_pkg::*;
(
    input  logic                 two_pulse,
    input  logic                 ivl4,
    input  idx_t                 idx,
    input  lvl_t                 level,
    input  logic [PAGE_LO_W-1:0] page_lo,
    input  byte_t                page_hi,
    input  logic [VBASE_W-1:0]   vec_base,
    input  logic                 poll_rd,
    input  logic                 poll_valid,
    input  lvl_t                 poll_level,
    output byte_t                data
);
    byte_t low_byte;

    // Low address byte: handler spacing decides where the level sits.
    always_comb begin
        if (ivl4) low_byte = {page_lo, level, 2'b00};
        else      low_byte = {page_lo[PAGE_LO_W-1:1], level, 3'b000};
    end

    // Byte select by mode and pulse index.
    always_comb begin
        if (poll_rd) begin
            data = {poll_valid, {(DATA_W-LVL_W-1){1'b0}}, poll_level};
        end else if (two_pulse) begin
            data = {vec_base, level};
        end else begin
            unique case (idx)
                2'd0:    data = CALL_OPCODE;
                2'd1:    data = low_byte;
                default: data = page_hi;
            endcase
        end
    end
endmodule

// File: rtl/ack_vector_seq.sv
// Module: ack_vector_seq (top)
// Counts acknowledge pulses, latches the winning level at the first one,
// drives call/address or vector bytes per mode and cascade role, drives the
// master cascade identity, handles poll reads and emits freeze,
// set-in-service and automatic end-of-interrupt strobes.
// Assumes configuration is static within a sequence and that acknowledge
// and poll reads never overlap.
module ack_vector_seq
    import ackseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_init,
    input  logic                 poll_arm,
    input  logic                 ack_n,
    input  logic                 rd_n,
    input  logic                 win_valid,
    input  logic [LVL_W-1:0]     win_level,
    input  logic                 cfg_two_pulse,
    input  logic                 cfg_ivl4,
    input  logic                 cfg_auto_eoi,
    input  logic                 cfg_cascaded,
    input  logic                 cfg_master,
    input  logic [N_LVL-1:0]     cfg_id_map,
    input  logic [PAGE_LO_W-1:0] cfg_page_lo,
    input  logic [DATA_W-1:0]    cfg_page_hi,
    input  logic [VBASE_W-1:0]   cfg_vec_base,
    input  logic [LVL_W-1:0]     cas_in,
    output logic [DATA_W-1:0]    data_out,
    output logic                 data_oe,
    output logic [LVL_W-1:0]     cas_out,
    output logic                 freeze,
    output logic                 set_isr,
    output logic [LVL_W-1:0]     set_level,
    output logic                 aeoi
);
    logic ack_act, ack_start, ack_end;
    logic rd_act,  rd_start,  rd_end;

    idx_t  cnt_q, idx_q, last_idx;
    lvl_t  lvl_q, plvl_q, cas_q, setlvl_q;
    logic  in_ack_q, in_poll_q, poll_pend_q, poll_valid_q;
    logic  freeze_q, set_q, aeoi_q, oe_q;
    byte_t dout_q, fmt_byte;

    lvl_t  m_cas;
    logic  m_defers, s_role, s_hit, ack_drive, drive;

    strobe_edge #(.STAGES(SYNC_STAGES)) u_ack_edge (
        .clk(clk), .rst_n(rst_n), .strobe_n(ack_n),
        .active(ack_act), .start(ack_start), .finish(ack_end)
    );

    strobe_edge #(.STAGES(SYNC_STAGES)) u_rd_edge (
        .clk(clk), .rst_n(rst_n), .strobe_n(rd_n),
        .active(rd_act), .start(rd_start), .finish(rd_end)
    );

    cascade_sel u_cas (
        .cascaded(cfg_cascaded), .master(cfg_master), .id_map(cfg_id_map),
        .level(lvl_q), .cas_in(cas_in), .master_cas(m_cas),
        .master_defers(m_defers), .slave_role(s_role), .slave_hit(s_hit)
    );

    vector_fmt u_fmt (
        .two_pulse(cfg_two_pulse), .ivl4(cfg_ivl4), .idx(idx_q),
        .level(lvl_q), .page_lo(cfg_page_lo), .page_hi(cfg_page_hi),
        .vec_base(cfg_vec_base), .poll_rd(in_poll_q),
        .poll_valid(poll_valid_q), .poll_level(plvl_q), .data(fmt_byte)
    );

    // Index of the final pulse for the selected bus mode.
    assign last_idx = cfg_two_pulse ? 2'd1 : 2'd2;

    // Bus drive decision for the pulse in progress.
    always_comb begin
        if (s_role)             ack_drive = (idx_q != 2'd0) & s_hit;
        else if (idx_q == 2'd0) ack_drive = ~cfg_two_pulse;
        else                    ack_drive = ~m_defers;
        drive = (in_poll_q & rd_act) | (in_ack_q & ack_act & ack_drive);
    end

    // Sequence state: pulse counter, level latch, cascade hold and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            idx_q        <= '0;
            lvl_q        <= '0;
            plvl_q       <= '0;
            cas_q        <= '0;
            setlvl_q     <= '0;
            in_ack_q     <= 1'b0;
            in_poll_q    <= 1'b0;
            poll_pend_q  <= 1'b0;
            poll_valid_q <= 1'b0;
            freeze_q     <= 1'b0;
            set_q        <= 1'b0;
            aeoi_q       <= 1'b0;
        end else begin
            freeze_q <= 1'b0;
            set_q    <= 1'b0;
            aeoi_q   <= 1'b0;
            if (cfg_init) begin
                cnt_q       <= '0;
                idx_q       <= '0;
                cas_q       <= '0;
                in_ack_q    <= 1'b0;
                in_poll_q   <= 1'b0;
                poll_pend_q <= 1'b0;
            end else begin
                if (poll_arm) poll_pend_q <= 1'b1;
                if (ack_start) begin
                    in_ack_q <= 1'b1;
                    idx_q    <= cnt_q;
                    if (cnt_q == 2'd0) begin
                        freeze_q <= 1'b1;
                        set_q    <= win_valid;
                        setlvl_q <= win_level;
                        lvl_q    <= win_valid ? win_level : LVL_FALLBACK;
                    end
                end
                if (ack_end && in_ack_q) begin
                    in_ack_q <= 1'b0;
                    if (idx_q == last_idx) begin
                        cnt_q  <= '0;
                        cas_q  <= '0;
                        aeoi_q <= cfg_auto_eoi;
                    end else begin
                        cnt_q <= idx_q + 2'd1;
                        if (idx_q == 2'd0) cas_q <= m_cas;
                    end
                end
                if (rd_start && poll_pend_q) begin
                    in_poll_q    <= 1'b1;
                    freeze_q     <= 1'b1;
                    set_q        <= win_valid;
                    setlvl_q     <= win_level;
                    poll_valid_q <= win_valid;
                    plvl_q       <= win_valid ? win_level : '0;
                end
                if (rd_end && in_poll_q) begin
                    in_poll_q   <= 1'b0;
                    poll_pend_q <= 1'b0;
                end
            end
        end
    end

    // Output register: bus byte and its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q   <= 1'b0;
            dout_q <= '0;
        end else begin
            oe_q   <= drive & ~cfg_init;
            dout_q <= fmt_byte;
        end
    end

    assign data_out  = dout_q;
    assign data_oe   = oe_q;
    assign cas_out   = cas_q;
    assign freeze    = freeze_q;
    assign set_isr   = set_q;
    assign set_level = setlvl_q;
    assign aeoi      = aeoi_q;
endmodule

// File: rtl/ack_vector_seq_chk.sv
// Module: ack_vector_seq_chk
// Property checker bound to ack_vector_seq. Assumes static configuration
// and a stable cas_in within a sequence.
module ack_vector_seq_chk
    import ackseq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ack_n,
    input logic             rd_n,
    input logic             cfg_auto_eoi,
    input logic             cfg_cascaded,
    input logic             cfg_master,
    input logic [N_LVL-1:0] cfg_id_map,
    input logic [LVL_W-1:0] cas_in,
    input logic             data_oe,
    input logic [LVL_W-1:0] cas_out,
    input logic             freeze,
    input logic             set_isr,
    input logic             aeoi
);
    AST_OE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!$past(ack_n, 4) || !$past(rd_n, 4))); // R9
    AST_CAS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_cascaded && cfg_master) |-> (cas_out == '0)); // R6
    AST_SLAVE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && cfg_cascaded && !cfg_master && $past(rd_n, 4))
        |-> (cas_in == cfg_id_map[LVL_W-1:0])); // R7
    AST_AEOI_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        aeoi |-> cfg_auto_eoi); // R4
    AST_SET_WITH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        set_isr |-> freeze); // R11
    AST_FREEZE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> !freeze); // R11
endmodule

bind ack_vector_seq ack_vector_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .rd_n(rd_n),
    .cfg_auto_eoi(cfg_auto_eoi), .cfg_cascaded(cfg_cascaded),
    .cfg_master(cfg_master), .cfg_id_map(cfg_id_map), .cas_in(cas_in),
    .data_oe(data_oe), .cas_out(cas_out), .freeze(freeze),
    .set_isr(set_isr), .aeoi(aeoi)
);

// File: tb/test_ack_vector_seq.sv
module test_ack_vector_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_init = 1'b0, poll_arm = 1'b0;
    logic       ack_n = 1'b1, rd_n = 1'b1;
    logic       win_valid = 1'b0;
    logic [2:0] win_level = '0;
    logic       cfg_two_pulse = 1'b0, cfg_ivl4 = 1'b0, cfg_auto_eoi = 1'b0;
    logic       cfg_cascaded = 1'b0, cfg_master = 1'b1;
    logic [7:0] cfg_id_map = '0;
    logic [2:0] cfg_page_lo = '0;
    logic [7:0] cfg_page_hi = '0;
    logic [4:0] cfg_vec_base = '0;
    logic [2:0] cas_in = '0;
    logic [7:0] data_out;
    logic       data_oe;
    logic [2:0] cas_out;
    logic       freeze, set_isr, aeoi;
    logic [2:0] set_level;

    int errors = 0, checks = 0;
    int n_frz = 0, n_set = 0, n_aeoi = 0;
    int last_set = 0;

    always #4 clk = ~clk;

    ack_vector_seq i_ack_vector_seq (
        .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .poll_arm(poll_arm),
        .ack_n(ack_n), .rd_n(rd_n), .win_valid(win_valid),
        .win_level(win_level), .cfg_two_pulse(cfg_two_pulse),
        .cfg_ivl4(cfg_ivl4), .cfg_auto_eoi(cfg_auto_eoi),
        .cfg_cascaded(cfg_cascaded), .cfg_master(cfg_master),
        .cfg_id_map(cfg_id_map), .cfg_page_lo(cfg_page_lo),
        .cfg_page_hi(cfg_page_hi), .cfg_vec_base(cfg_vec_base),
        .cas_in(cas_in), .data_out(data_out), .data_oe(data_oe),
        .cas_out(cas_out), .freeze(freeze), .set_isr(set_isr),
        .set_level(set_level), .aeoi(aeoi)
    );

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (freeze) n_frz++;
            if (set_isr) begin n_set++; last_set = int'(set_level); end
            if (aeoi) n_aeoi++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One strobe pulse; returns oe and byte sampled mid-pulse.
    task automatic pulse(input bit use_rd, output bit oe, output int d);
        @(negedge clk);
        if (use_rd) rd_n = 1'b0; else ack_n = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        oe = data_oe; d = int'(data_out);
        if (use_rd) rd_n = 1'b1; else ack_n = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(data_oe == 1'b0, "R9 oe low after strobe", int'(data_oe), 0);
    endtask

    task automatic one_cycle(ref logic sig);
        @(negedge clk); sig = 1'b1; @(negedge clk); sig = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        bit oe; int d, s0, a0, f0, exp;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(data_oe == 0 && cas_out == 0 && freeze == 0, "R9 reset state", int'(data_oe), 0);

        // R1 R2 R4 R11: three-pulse sweep over spacing and level.
        cfg_two_pulse = 1'b0;
        for (int iv = 0; iv < 2; iv++) begin
            for (int lv = 0; lv < 8; lv++) begin
                cfg_ivl4 = iv[0]; cfg_auto_eoi = lv[0];
                cfg_page_lo = 3'(lv ^ 5); cfg_page_hi = 8'(8'h31 + lv * 17);
                win_valid = 1'b1; win_level = 3'(lv);
                s0 = n_set; a0 = n_aeoi; f0 = n_frz;
                pulse(0, oe, d);
                chk(oe && d == 8'hCD, "R1 call byte", d, 8'hCD);
                chk(n_set == s0 + 1 && last_set == lv && n_frz == f0 + 1, "R11 set level", last_set, lv);
                pulse(0, oe, d);
                exp = iv ? (int'(cfg_page_lo) * 32 + lv * 4) : ((int'(cfg_page_lo) / 2) * 64 + lv * 8);
                chk(oe && d == exp, "R2 low address byte", d, exp);
                chk(n_aeoi == a0, "R4 no eoi before last", n_aeoi - a0, 0);
                pulse(0, oe, d);
                chk(oe && d == int'(cfg_page_hi), "R1 high address byte", d, int'(cfg_page_hi));
                chk(n_aeoi == a0 + (lv % 2), "R4 auto eoi at last", n_aeoi - a0, lv % 2);
            end
        end

        // R3: two-pulse sweep; spacing must not matter.
        cfg_two_pulse = 1'b1;
        for (int iv = 0; iv < 2; iv++) begin
            for (int lv = 0; lv < 8; lv++) begin
                cfg_ivl4 = iv[0]; cfg_auto_eoi = ~lv[0];
                cfg_vec_base = 5'(lv * 3 + 1); win_level = 3'(lv);
                s0 = n_set; a0 = n_aeoi;
                pulse(0, oe, d);
                chk(!oe, "R3 first pulse silent", int'(oe), 0);
                chk(n_aeoi == a0 && n_set == s0 + 1, "R4 R3 eoi/set after first", n_aeoi - a0, 0);
                pulse(0, oe, d);
                exp = int'(cfg_vec_base) * 8 + lv;
                chk(oe && d == exp, "R3 vector byte", d, exp);
                chk(n_aeoi == a0 + 1 - (lv % 2), "R4 eoi after second", n_aeoi - a0, 1 - (lv % 2));
            end
        end

        // R5: vanished request answers as level 7 without setting service.
        cfg_two_pulse = 1'b0; cfg_ivl4 = 1'b1; cfg_auto_eoi = 1'b0;
        cfg_page_lo = 3'd2; win_valid = 1'b0; win_level = 3'd3;
        s0 = n_set; f0 = n_frz;
        pulse(0, oe, d);
        chk(n_set == s0 && n_frz == f0 + 1, "R5 no set on fallback", n_set - s0, 0);
        pulse(0, oe, d);
        chk(oe && d == 2 * 32 + 7 * 4, "R5 fallback low byte", d, 2 * 32 + 28);
        pulse(0, oe, d);

        // R6: cascaded master sweep, two-pulse mode.
        cfg_two_pulse = 1'b1; cfg_cascaded = 1'b1; cfg_master = 1'b1;
        cfg_id_map = 8'hA4; cfg_vec_base = 5'd9; win_valid = 1'b1;
        for (int lv = 0; lv < 8; lv++) begin
            win_level = 3'(lv);
            exp = cfg_id_map[lv] ? lv : 0;
            chk(cas_out == 0, "R6 cas idle before", int'(cas_out), 0);
            pulse(0, oe, d);
            chk(int'(cas_out) == exp, "R6 cascade identity", int'(cas_out), exp);
            pulse(0, oe, d);
            chk(oe == !cfg_id_map[lv], "R6 master defers bytes", int'(oe), int'(!cfg_id_map[lv]));
            chk(cas_out == 0, "R6 cas released", int'(cas_out), 0);
        end
        win_valid = 1'b0;
        pulse(0, oe, d);
        chk(cas_out == 3'd7, "R5 fallback cascade id", int'(cas_out), 7);
        pulse(0, oe, d);

        // R7: slave with identity 5, three-pulse, sweep cas_in.
        cfg_two_pulse = 1'b0; cfg_master = 1'b0; cfg_id_map = 8'h05;
        cfg_page_hi = 8'h6E; win_valid = 1'b1; win_level = 3'd1;
        for (int c = 0; c < 8; c++) begin
            cas_in = 3'(c);
            pulse(0, oe, d);
            chk(!oe, "R7 slave silent on first", int'(oe), 0);
            pulse(0, oe, d);
            chk(oe == (c == 5), "R7 slave second on match", int'(oe), int'(c == 5));
            pulse(0, oe, d);
            chk(oe == (c == 5) && (c != 5 || d == 8'h6E), "R7 slave third", d, 8'h6E);
            chk(cas_out == 0, "R6 slave cas quiet", int'(cas_out), 0);
        end
        cfg_cascaded = 1'b0; cfg_master = 1'b1; cas_in = '0;

        // R8: poll read sweep.
        for (int v = 0; v < 2; v++) begin
            for (int lv = 0; lv < 8; lv += 3) begin
                win_valid = v[0]; win_level = 3'(lv);
                s0 = n_set;
                one_cycle(poll_arm);
                pulse(1, oe, d);
                exp = v ? 128 + lv : 0;
                chk(oe && d == exp, "R8 poll byte", d, exp);
                chk(n_set == s0 + v && (v == 0 || last_set == lv), "R8 poll set", n_set - s0, v);
            end
        end
        pulse(1, oe, d);
        chk(!oe, "R8 plain read silent", int'(oe), 0);

        // R10: initialization mid-sequence restarts the count.
        win_valid = 1'b1; win_level = 3'd4; cfg_auto_eoi = 1'b1;
        pulse(0, oe, d);
        one_cycle(cfg_init);
        a0 = n_aeoi;
        pulse(0, oe, d);
        chk(oe && d == 8'hCD, "R10 restart at call byte", d, 8'hCD);
        pulse(0, oe, d);
        chk(n_aeoi == a0, "R10 no early eoi", n_aeoi - a0, 0);
        pulse(0, oe, d);
        chk(n_aeoi == a0 + 1, "R10 eoi on third", n_aeoi - a0, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule